// File: doc/BRIEF.md
# Flash Converter Thermometer-to-Gray Encoder

This block is the digital back end of a flash analog-to-digital converter. Each conversion clock it captures the resolved outputs of the comparator bank as a thermometer vector, with bit k set when the analog input lies above reference level k+1. A window of three neighbouring comparator outputs forms a one-hot row select at the single rising transition of the vector. That row addresses a ROM-style encoder, which produces the level as a reflected Gray word in an output register.

The Gray format keeps the damage small when a comparator near the transition stays undecided, or when a bubble gets past the window and selects two rows. Then the ROM returns the bitwise OR of the selected words. One code is accepted every cycle. The word for the vector sampled at a rising edge is visible right after that edge. The resolution `NBITS` sets the vector width to 2^NBITS-1. The window can be reduced to two inputs through `WIN`.

Top module: `tg_encoder`

## Requirements
- R1: For a clean thermometer input holding n ones in bits 0..n-1, the output equals the Gray word n XOR (n>>1), with bit 0 of the output as the least significant Gray bit.
- R2: The input present at a rising clock edge is encoded and registered on that edge, so the output changes once per cycle and the new word is visible right after the sampling edge.
- R3: When the synchronous active-high reset is high at a rising edge, the output becomes all zeros at that edge, whatever the input.
- R4: An all-zero input gives output 0. An all-one input gives the Gray word of level 2^NBITS-1, which is 0x80 for 8 bits.
- R5: Take a clean input of level n ≥ 2 and clear any single bit j with j ≤ n-2. The output is still the Gray word of n.
- R6: Take a clean input of level n and set one stray bit j with n+2 ≤ j ≤ 2^NBITS-2. The output is the bitwise OR of the Gray words of n and of j+1.
- R7: Take a clean input of level n ≤ 2^NBITS-3 and set the stray bit j = n+1 (one zero between the edge and the stray one). The output is the Gray word of n+2.
- R8: Clean inputs of adjacent levels n and n+1 give output words that differ in exactly one bit. An undecided comparator at the transition therefore costs at most one LSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; input sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| therm_i | input | 2^NBITS-1 (255) | Comparator outputs, bit k set when the input is above level k+1 |
| gray_o | output | NBITS (8) | Registered Gray-coded conversion result |

## Verification
On every cycle the assertions check three things: the reset clearing of the output, the Gray word produced for any clean thermometer input, including both extreme codes, and the single-bit change between adjacent clean levels. The bubble rules need input patterns that no per-cycle property can classify cheaply. These are the zero holes below the edge, the stray ones above it and the case of a stray one next to the edge. The bench shows them by sweeping every single-bit variant of every level and predicting the OR of the Gray words arithmetically.

// File: rtl/tg_pkg.sv
package tg_pkg;
   localparam int unsigned TG_MIN_BITS = 2;
   localparam int unsigned TG_MAX_BITS = 10;

   // reflected binary Gray code of a level
   function automatic int unsigned tg_gray(input int unsigned lvl);
      return lvl ^ (lvl >> 1);
   endfunction
endpackage

// File: rtl/tg_row_select.sv
// Forms the one-hot row selects from a window over adjacent comparators.
// Row 0 carries the zero word and is not generated.
module tg_row_select #(
   parameter int unsigned NBITS = 8,
   parameter int unsigned WIN   = 3,
   localparam int unsigned NLEV = (1 << NBITS) - 1
) (
   input  logic [NLEV-1:0] therm_i,
   output logic [NLEV:1]   rows_o
);
   localparam int unsigned PAD = WIN - 1;

   // comparators beyond the top of the ladder read as zero
   logic [NLEV+PAD-1:0] ext;
   assign ext = {{PAD{1'b0}}, therm_i};

   generate
      if (WIN == 3) begin : g_win3
         for (genvar k = 0; k < NLEV; k++) begin : g_row
            assign rows_o[k+1] = ext[k] & ~ext[k+1] & ~ext[k+2];
         end
      end else begin : g_win2
         for (genvar k = 0; k < NLEV; k++) begin : g_row
            assign rows_o[k+1] = ext[k] & ~ext[k+1];
         end
      end
   endgenerate
endmodule

// File: rtl/tg_rom.sv
// Wired-OR ROM: each output bit ORs the rows whose Gray word has that bit.
module tg_rom #(
   parameter int unsigned NBITS = 8,
   localparam int unsigned NLEV = (1 << NBITS) - 1
) (
   input  logic [NLEV:1]    rows_i,
   output logic [NBITS-1:0] word_o
);
   import tg_pkg::*;

   generate
      for (genvar b = 0; b < NBITS; b++) begin : g_bit
         logic [NLEV:1] hit;
         for (genvar r = 1; r <= NLEV; r++) begin : g_cell
            if (((tg_gray(r) >> b) & 1) != 0) begin : g_on
               assign hit[r] = rows_i[r];
            end else begin : g_off
               assign hit[r] = 1'b0;
            end
         end
         assign word_o[b] = |hit;
      end
   endgenerate
endmodule

// File: rtl/tg_out_reg.sv
module tg_out_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (rst) q_o <= '0;
      else     q_o <= d_i;
   end
endmodule

// File: rtl/tg_encoder.sv
module tg_encoder #(
   parameter int unsigned NBITS = 8,
   parameter int unsigned WIN   = 3,
   localparam int unsigned NLEV = (1 << NBITS) - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NLEV-1:0]  therm_i,
   output logic [NBITS-1:0] gray_o
);
   import tg_pkg::*;

   generate
      if (NBITS < TG_MIN_BITS || NBITS > TG_MAX_BITS) begin : g_bad_bits
         $error("tg_encoder: NBITS out of supported range");
      end
      if (WIN != 2 && WIN != 3) begin : g_bad_win
         $error("tg_encoder: WIN must be 2 or 3");
      end
   endgenerate

   logic [NLEV:1]    rows;
   logic [NBITS-1:0] word;

   tg_row_select #(.NBITS(NBITS), .WIN(WIN)) u_rows (
      .therm_i (therm_i),
      .rows_o  (rows)
   );

   tg_rom #(.NBITS(NBITS)) u_rom (
      .rows_i (rows),
      .word_o (word)
   );

   tg_out_reg #(.W(NBITS)) u_oreg (
      .clk (clk),
      .rst (rst),
      .d_i (word),
      .q_o (gray_o)
   );
endmodule

// File: rtl/tg_encoder_chk.sv
module tg_encoder_chk #(
   parameter int unsigned NBITS = 8,
   localparam int unsigned NLEV = (1 << NBITS) - 1
) (
   input logic             clk,
   input logic             rst,
   input logic [NLEV-1:0]  therm_i,
   input logic [NBITS-1:0] gray_o
);
   import tg_pkg::*;

   logic             clean;
   int unsigned      lvl;
   logic [NBITS-1:0] model;

   assign clean = ((therm_i & (therm_i + 1'b1)) == '0);
   assign lvl   = $countones(therm_i);
   assign model = NBITS'(tg_gray(lvl));

   // R3: reset clears the output at the edge
   p_reset_zero_r3: assert property (@(posedge clk)
      rst |=> gray_o == '0);

   // R1 / R2: clean code sampled last edge appears now as its Gray word
   p_clean_code_r1: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(clean)) |-> gray_o == $past(model));

   // R4: all-zero input
   p_all_zero_r4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(therm_i == '0)) |-> gray_o == '0);

   // R4: all-one input
   p_all_ones_r4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(&therm_i)) |-> gray_o == NBITS'(tg_gray(NLEV)));

   // R8: adjacent clean levels change one output bit
   p_adjacent_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2) && $past(clean) && $past(clean, 2)
       && ($past(lvl) == $past(lvl, 2) + 1))
      |-> $countones(gray_o ^ $past(gray_o)) == 1);
endmodule

bind tg_encoder tg_encoder_chk #(.NBITS(NBITS)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .therm_i (therm_i),
   .gray_o  (gray_o)
);

// File: tb/tg_encoder_tb_top.sv
`timescale 1ns/1ps
module tg_encoder_tb_top;
   localparam int NB   = 8;
   localparam int NLEV = (1 << NB) - 1;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [NLEV-1:0] therm = '0;
   logic [NB-1:0]   gray;

   int n_checks = 0;
   int n_errors = 0;
   bit pend     = 1'b0;
   logic [NB-1:0] pend_exp;
   string         pend_tag;
   logic [NB-1:0] prev_word;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tg_encoder #(.NBITS(NB)) dut_i (
      .clk     (clk),
      .rst     (rst),
      .therm_i (therm),
      .gray_o  (gray)
   );

   function automatic logic [NB-1:0] gw(input int n);
      return NB'(n ^ (n >> 1));
   endfunction

   function automatic logic [NLEV-1:0] th(input int n);
      logic [NLEV-1:0] t;
      for (int k = 0; k < NLEV; k++) t[k] = (k < n);
      return t;
   endfunction

   task automatic check(input logic [NB-1:0] act, input logic [NB-1:0] exp,
                        input string tag);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // pipelined: at each falling edge check the previous word, drive the next
   task automatic step(input logic [NLEV-1:0] t, input logic [NB-1:0] exp,
                       input string tag);
      @(negedge clk);
      if (pend) check(gray, pend_exp, pend_tag);
      therm    = t;
      pend     = 1'b1;
      pend_exp = exp;
      pend_tag = tag;
   endtask

   task automatic flush();
      @(negedge clk);
      if (pend) check(gray, pend_exp, pend_tag);
      pend = 1'b0;
   endtask

   initial begin
      therm = '1;
      repeat (3) @(negedge clk);
      check(gray, '0, "R3 reset state");
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(gray, gw(NLEV), "R2 first word after reset");

      // R1, R4, R8: every clean level in rising order
      for (int n = 0; n <= NLEV; n++) step(th(n), gw(n), "R1 clean level");
      flush();
      // R2: one word per cycle, each visible after its sampling edge
      step(th(3), gw(3), "R2 back-to-back a");
      step(th(200), gw(200), "R2 back-to-back b");
      step('0, '0, "R4 all zero");
      step('1, gw(NLEV), "R4 all ones");
      flush();

      // R8: adjacent levels differ in exactly one bit
      @(negedge clk); therm = th(0);
      @(negedge clk);
      prev_word = gray;
      for (int n = 1; n <= NLEV; n++) begin
         therm = th(n);
         @(negedge clk);
         n_checks++;
         if ($countones(gray ^ prev_word) != 1) begin
            n_errors++;
            $display("FAIL R8 level %0d: got %h expected one-bit change from %h",
                     n, gray, prev_word);
         end
         prev_word = gray;
      end

      // R5: every single zero hole below the edge
      for (int n = 2; n <= NLEV; n++) begin
         for (int j = 0; j <= n - 2; j++) begin
            logic [NLEV-1:0] t;
            t = th(n);
            t[j] = 1'b0;
            step(t, gw(n), "R5 zero bubble");
         end
      end
      // R6, R7: every single stray one above the edge
      for (int n = 0; n <= NLEV - 2; n++) begin
         for (int j = n + 1; j <= NLEV - 1; j++) begin
            logic [NLEV-1:0] t;
            t = th(n);
            t[j] = 1'b1;
            if (j == n + 1) step(t, gw(n + 2), "R7 stray one at edge");
            else            step(t, gw(n) | gw(j + 1), "R6 stray one OR");
         end
      end
      flush();

      // R3: reset mid-stream overrides the input
      @(negedge clk); therm = '1; rst = 1'b1;
      @(negedge clk);
      check(gray, '0, "R3 reset overrides input");
      rst = 1'b0;
      @(negedge clk);
      check(gray, gw(NLEV), "R3 release resumes");
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (190000) @(posedge clk);
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule